// File: doc/BRIEF.md
# Bank Batch Age Guard

This block bounds how long a request waiting at the head of a bank queue can be passed over by later, better-placed work. It keeps one flag per bank and one shared age counter. When no flag is set, it marks every bank whose queue holds a request as a member of a new batch and restarts the age count. The count then rises by one per cycle. Each issue from a bank clears that bank's flag.

The scheduler beside it reports which bank queues are nonempty and which bank issued in the current cycle. The block returns an eligibility mask. While the batch is young, every bank may issue. Once the age passes twice the bank busy time, only banks still holding a member of the batch may issue, until that batch has drained. The bank busy time and the bank count are parameters. Queue storage and arbitration sit outside the block.

Top module: `batch_age_guard`

## Requirements
- R1: An active-low asynchronous reset clears all batch flags and the age count, so every bit of `elig_o` reads 1 during and right after reset.
- R2: At a clock edge where no batch flag is set, each bank's flag loads `nonempty_i[b] & ~issue_i[b]` and the age count goes to zero.
- R3: At a clock edge where at least one flag is set, the age count rises by exactly one.
- R4: An `issue_i[b]` pulse clears bank b's flag at that edge. An issue from a bank whose flag is clear leaves every flag unchanged.
- R5: While the age count is at or below 2*BANK_BUSY, `elig_o` is all ones.
- R6: While the age count is above 2*BANK_BUSY and some flag is set, `elig_o` equals the flag vector, with bit b for bank b.
- R7: While no flag is set, `elig_o` is all ones, whatever the age count.
- R8: The age count saturates at its all-ones value and does not wrap, so a lockout stays in force however long the batch waits.
- R9: While every queue is empty, no batch forms and the age count is held at zero every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nonempty_i | input | NUM_BANKS | Bit b is 1 when bank b's queue holds a request |
| issue_i | input | NUM_BANKS | Bit b pulses for the cycle in which bank b issues |
| elig_o | output | NUM_BANKS | Bit b is 1 when bank b may issue this cycle |

## Verification
A flag that fails to clear shows up only after the lockout threshold, as a bank that stays eligible alone, and it blocks the rest until a reset. An age count that is off by one moves the first narrowed mask by one cycle, so the bench samples both the last all-ones cycle and the first narrowed cycle. A counter that wraps instead of saturating reopens the mask 2^AGE_W cycles after the batch formed. The bench holds a batch past that point. A batch formed from the wrong banks shows as a wrong mask in the first locked-out cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;

   // Width of an age count that can sit above the lockout threshold
   // (2*busy) with headroom before saturating.
   function automatic int age_width(input int busy);
      return $clog2(2 * busy + 1) + 1;
   endfunction

   typedef enum logic [0:0] {
      PH_OPEN   = 1'b0,   // every bank may issue
      PH_LOCKED = 1'b1    // only members of the batch may issue
   } gate_phase_e;

endpackage

// File: rtl/bag_age_ctr.sv
module bag_age_ctr #(
   parameter int BANK_BUSY = 6,
   parameter int AGE_W     = bag_pkg::age_width(BANK_BUSY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   output logic [AGE_W-1:0] age_o,
   output logic             over_o
);
   localparam int             LIMIT   = 2 * BANK_BUSY;
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
   localparam logic [AGE_W-1:0] LIMIT_W = AGE_W'(LIMIT);

   generate
      if (LIMIT >= (1 << AGE_W) - 1) begin : g_bad_width
         $error("AGE_W too small for threshold");
      end
   endgenerate

   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= '0;
      end else if (restart_i) begin
         age_q <= '0;
      end else if (age_q != AGE_MAX) begin
         age_q <= age_q + AGE_W'(1);
      end
   end

   assign age_o  = age_q;
   assign over_o = (age_q > LIMIT_W);

   p_age_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && age_q != AGE_MAX) |=> (age_q == $past(age_q) + AGE_W'(1)));

   p_age_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && age_q == AGE_MAX) |=> (age_q == AGE_MAX));

   p_age_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (age_q == '0));

endmodule

// File: rtl/bag_flag_bank.sv
module bag_flag_bank #(
   parameter int NUM_BANKS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 form_i,
   input  logic [NUM_BANKS-1:0] nonempty_i,
   input  logic [NUM_BANKS-1:0] issue_i,
   output logic [NUM_BANKS-1:0] member_o
);
   logic [NUM_BANKS-1:0] member_q;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               member_q[b] <= 1'b0;
            end else if (form_i) begin
               member_q[b] <= nonempty_i[b] & ~issue_i[b];
            end else if (issue_i[b]) begin
               member_q[b] <= 1'b0;
            end
         end

         p_issue_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            issue_i[b] |=> !member_q[b]);

         p_idle_bank_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!form_i && !issue_i[b]) |=> (member_q[b] == $past(member_q[b])));
      end
   endgenerate

   assign member_o = member_q;

endmodule

// File: rtl/bag_elig_mask.sv
module bag_elig_mask #(
   parameter int NUM_BANKS = 8
) (
   input  logic                 over_i,
   input  logic [NUM_BANKS-1:0] member_i,
   output logic [NUM_BANKS-1:0] elig_o
);
   import bag_pkg::*;

   gate_phase_e phase;

   always_comb begin
      phase = (over_i && (|member_i)) ? PH_LOCKED : PH_OPEN;
      unique case (phase)
         PH_LOCKED: elig_o = member_i;
         default:   elig_o = '1;
      endcase
   end

endmodule

// File: rtl/batch_age_guard.sv
module batch_age_guard #(
   parameter int NUM_BANKS = 8,
   parameter int BANK_BUSY = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] nonempty_i,
   input  logic [NUM_BANKS-1:0] issue_i,
   output logic [NUM_BANKS-1:0] elig_o
);
   localparam int AGE_W = bag_pkg::age_width(BANK_BUSY);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("NUM_BANKS must be at least 1");
      end
      if (BANK_BUSY < 1) begin : g_bad_busy
         $error("BANK_BUSY must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0] member;
   logic [AGE_W-1:0]     age;
   logic                 over;
   logic                 form;

   assign form = ~|member;

   bag_flag_bank #(.NUM_BANKS(NUM_BANKS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .form_i     (form),
      .nonempty_i (nonempty_i),
      .issue_i    (issue_i),
      .member_o   (member)
   );

   bag_age_ctr #(.BANK_BUSY(BANK_BUSY), .AGE_W(AGE_W)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (form),
      .age_o     (age),
      .over_o    (over)
   );

   bag_elig_mask #(.NUM_BANKS(NUM_BANKS)) u_mask (
      .over_i   (over),
      .member_i (member),
      .elig_o   (elig_o)
   );

   p_batch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (member == '0) |=> (member == ($past(nonempty_i) & ~$past(issue_i))));

   p_idle_age_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((member == '0) && (nonempty_i == '0)) |=> (age == '0));

   p_issue_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (over && (member != '0)) |-> ((issue_i & ~member) == '0));

endmodule

// File: tb/batch_age_guard_tb_top.sv
`timescale 1ns/1ps
module batch_age_guard_tb_top;
   localparam int NB   = 4;
   localparam int BUSY = 3;   // lockout once age > 6; age saturates at 15

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] nonempty = '0;
   logic [NB-1:0] issue = '0;
   logic [NB-1:0] elig;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   batch_age_guard #(.NUM_BANKS(NB), .BANK_BUSY(BUSY)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .nonempty_i (nonempty),
      .issue_i    (issue),
      .elig_o     (elig)
   );

   task automatic chk(input logic [NB-1:0] exp, input string req);
      n_cmp++;
      if (elig !== exp) begin
         n_bad++;
         $display("FAIL %s: elig_o=%b expected=%b at %0t", req, elig, exp, $time);
      end
   endtask

   // apply inputs, take one clock edge, settle past it
   task automatic step(input logic [NB-1:0] ne, input logic [NB-1:0] is);
      nonempty = ne;
      issue    = is;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #1 chk(4'b1111, "R1 in reset");
      repeat (3) step(4'b0000, 4'b0000);
      rst_n = 1'b1;
      step(4'b0000, 4'b0000);
      chk(4'b1111, "R1 after reset");
   endtask

   task automatic t_lockout();
      step(4'b0011, 4'b0000);                 // batch {0,1}, age 0
      chk(4'b1111, "R2 batch formed, young");
      repeat (5) step(4'b1111, 4'b0000);      // age 5
      step(4'b1111, 4'b0100);                 // bank 2 not in batch, age 6
      chk(4'b1111, "R5 age at threshold");
      step(4'b1111, 4'b0000);                 // age 7
      chk(4'b0011, "R6 R3 first locked cycle; R4 bank2 issue no effect");
      step(4'b1111, 4'b0001);                 // bank 0 leaves batch
      chk(4'b0010, "R4 issue clears flag");
      step(4'b1111, 4'b0010);                 // batch drained
      chk(4'b1111, "R7 no flags, all eligible");
   endtask

   task automatic t_saturate();
      step(4'b1100, 4'b0000);                 // batch {2,3}, age 0
      repeat (16) step(4'b1111, 4'b0000);     // age saturates at 15
      chk(4'b1100, "R8 no wrap after 16 cycles");
      repeat (4) step(4'b1111, 4'b0000);
      chk(4'b1100, "R8 still locked after 20 cycles");
      step(4'b1111, 4'b1100);
      chk(4'b1111, "R4 R7 both cleared together");
   endtask

   task automatic t_idle();
      repeat (10) step(4'b0000, 4'b0000);
      chk(4'b1111, "R9 idle queues");
      step(4'b0001, 4'b0000);                 // batch {0}, age 0
      repeat (6) step(4'b1111, 4'b0000);      // age 6
      chk(4'b1111, "R9 R5 age counted from batch start");
      step(4'b1111, 4'b0000);                 // age 7
      chk(4'b0001, "R3 R6 single-bank lockout");
      step(4'b1111, 4'b0001);
      chk(4'b1111, "R7 drained");
   endtask

   task automatic t_form_with_issue();
      step(4'b0110, 4'b0010);                 // bank 1 issues at formation
      repeat (7) step(4'b1111, 4'b0000);      // age 7
      chk(4'b0100, "R2 issuing bank left out of batch");
      step(4'b0000, 4'b0100);
      chk(4'b1111, "R7 drained");
   endtask

   task automatic t_reset_mid();
      step(4'b0011, 4'b0000);
      repeat (7) step(4'b1111, 4'b0000);
      chk(4'b0011, "R6 locked before reset");
      rst_n = 1'b0;
      #1 chk(4'b1111, "R1 async reset");
      repeat (2) step(4'b0000, 4'b0000);
      rst_n = 1'b1;
      step(4'b0000, 4'b0000);
      chk(4'b1111, "R1 released");
      step(4'b1000, 4'b0000);
      repeat (7) step(4'b1111, 4'b0000);
      chk(4'b1000, "R2 R6 fresh batch after reset");
      step(4'b0000, 4'b1000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_lockout();
      t_saturate();
      t_idle();
      t_form_with_issue();
      t_reset_mid();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule